// File: doc/BRIEF.md
# Multi-Channel Compare Timer

This block is an up-counting timer with a small register bus, three compare channels, a rollover flag and one level interrupt. The counter runs from one of two tick-enable inputs, both in the system clock domain. A 12-bit divider sits between the selected tick and the counter: with divider setting P, the counter steps once for every P+1 ticks. Software reads and writes the registers through a word-indexed bus. Writes take effect at the clock edge. Reads are combinational from the index.

The counter has two modes. In free-run mode it wraps from all-ones to zero and raises the rollover flag. In restart mode it goes back to zero after matching compare channel 1. Each compare channel raises its own status flag on the counting step that finds the counter equal to its value. Software clears a flag by writing a 1 to it, and a per-bit enable mask selects which flags drive the interrupt.

A software reset is requested through a control bit. It returns the block to its reset state but keeps the clock-source, mode and other upper control bits. The counter width `CNT_W` defaults to 32 and can be reduced. A smaller width shortens the wrap period, so rollover can be exercised in a short run.

Top module: `cmp_timer_top`

## Requirements
- R1: After a hardware reset, control, divider, status, interrupt enable and counter read 0, and each compare register reads all-ones (CNT_W bits).
- R2: The register index decodes as follows:
  - 0 control, 1 divider, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture, 9 counter.
  - Capture indices and indices 10 to 15 read 0.
  - Writes to indices 7, 8 and 9 change nothing.
  - Control stores the written value with bits 2, 4 and 10 to 15 forced to 0.
  - The divider keeps write bits 11:0, and interrupt enable keeps write bits 5:0.
- R3: Control bits 8:6 select the clock source. Code 1 or 2 selects `tick_per`, code 4 selects `tick_slow`, and any other code stops counting.
- R4: While enabled (control bit 0), the counter advances by one once every (divider+1) selected ticks.
- R5: With control bit 9 set (free-run), an advance from all-ones gives 0 and sets status bit 5.
- R6: With control bit 9 clear (restart), an advance while the counter equals compare 1 gives 0. A write to compare 1 in restart mode clears the counter to 0.
- R7: Status bits 0, 1 and 2 set on an advance in which the counter equals compare 1, 2 and 3 respectively. Several channels can set in the same step.
- R8: Writing status clears every bit among bits 5:0 written as 1. A flag being set in the same cycle wins over the clear.
- R9: `irq` is high exactly when control bit 0 is set and status AND interrupt enable is nonzero.
- R10: A control write with bit 15 set does the following:
  - Stores the written value with bits 5:0 and 15 cleared (bit 15 always reads 0).
  - Clears status, divider, interrupt enable, counter and the divider phase.
  - Returns each compare register to all-ones.
- R11: The enable bit controls counting as follows:
  - A control write that raises bit 0 while bit 1 is set restarts the counter and the divider phase from 0.
  - With bit 1 clear, counting resumes from the held value.
  - While bit 0 is clear, the counter holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| tick_per | input | 1 | Peripheral-rate tick enable |
| tick_slow | input | 1 | Slow-rate tick enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:
- The interrupt is gated by enable and by the masked flags.
- The counter holds while disabled, and otherwise it steps by at most one or returns to zero.
- Wrap sets the rollover flag in free-run mode, and a compare-1 match restarts the counter with flag 0 set.
- A software reset clears the low control bits, the counter and the flags.
- Written-one status bits drop while the timer is idle.

Other behaviours depend on chosen stimulus, so only the bench scenarios show them. These are:
- the clock-source decode and the divider ratio;
- the write masks and the ignored indices;
- several channels matching in one step;
- the difference between resuming and restarting on enable.

// File: rtl/cmp_timer_pkg.sv
`timescale 1ns/1ps
// Shared constants for the compare timer: register indices, control bit
// positions, status layout and control write masks.
package cmp_timer_pkg;
    localparam int unsigned ADDR_W     = 4;
    localparam int unsigned ST_W       = 6;

    localparam logic [ADDR_W-1:0] IDX_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] IDX_DIV    = 4'd1;
    localparam logic [ADDR_W-1:0] IDX_STATUS = 4'd2;
    localparam logic [ADDR_W-1:0] IDX_IEN    = 4'd3;
    localparam logic [ADDR_W-1:0] IDX_CMP0   = 4'd4;
    localparam logic [ADDR_W-1:0] IDX_COUNT  = 4'd9;

    localparam int unsigned CB_EN      = 0;
    localparam int unsigned CB_RSTART  = 1;
    localparam int unsigned CB_SRC_LO  = 6;
    localparam int unsigned CB_FREE    = 9;
    localparam int unsigned CB_SWR     = 15;
    localparam int unsigned ST_ROLL    = 5;

    // Bits 2, 4, 10..15 are never stored (bit 15 acts, then reads 0).
    localparam logic [31:0] CTRL_STORE = 32'hFFFF_03EB;
    // Bits kept by a software reset.
    localparam logic [31:0] CTRL_SOFT  = 32'hFFFF_03C0;

    typedef enum logic [2:0] {
        SRC_NONE0 = 3'd0,
        SRC_PER_A = 3'd1,
        SRC_PER_B = 3'd2,
        SRC_NONE3 = 3'd3,
        SRC_SLOW  = 3'd4
    } src_code_e;
endpackage

// File: rtl/cmp_timer_regs.sv
`timescale 1ns/1ps
// Register file of the compare timer: control, divider, interrupt enable and
// compare values. Decodes bus writes into the side-effect pulses (software
// reset, enable restart, compare-1 clear, status clear mask).
// Assumes a single write per cycle and a synchronous active-low reset.
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned PRE_W   = 12,
    parameter int unsigned NUM_CMP = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_we,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               ctrl_q,
    output logic [PRE_W-1:0]                div_q,
    output logic [ST_W-1:0]                 ien_q,
    output logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_q,
    output logic                            soft_rst,
    output logic                            en_start,
    output logic                            cmp1_clr,
    output logic [ST_W-1:0]                 sts_clr
);
    logic wr_ctrl;

    // Write decode and side-effect pulses.
    always_comb begin
        wr_ctrl  = bus_we && (bus_addr == IDX_CTRL);
        soft_rst = wr_ctrl && bus_wdata[CB_SWR];
        en_start = wr_ctrl && !soft_rst && !ctrl_q[CB_EN]
                   && bus_wdata[CB_EN] && bus_wdata[CB_RSTART];
        cmp1_clr = bus_we && (bus_addr == IDX_CMP0) && !ctrl_q[CB_FREE];
        sts_clr  = (bus_we && (bus_addr == IDX_STATUS)) ? bus_wdata[ST_W-1:0] : '0;
    end

    // Control register: masked store, software reset keeps upper fields.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= soft_rst ? (bus_wdata & CTRL_SOFT) : (bus_wdata & CTRL_STORE);
    end

    // Divider setting.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            div_q <= '0;
        else if (bus_we && (bus_addr == IDX_DIV))
            div_q <= bus_wdata[PRE_W-1:0];
    end

    // Interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            ien_q <= '0;
        else if (bus_we && (bus_addr == IDX_IEN))
            ien_q <= bus_wdata[ST_W-1:0];
    end

    // One compare register per channel.
    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        localparam logic [ADDR_W-1:0] MY_IDX = IDX_CMP0 + ADDR_W'(c);
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)
                cmp_q[c] <= '1;
            else if (bus_we && (bus_addr == MY_IDX))
                cmp_q[c] <= bus_wdata[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/cmp_timer_prescale.sv
`timescale 1ns/1ps
// Clock-source selection and divider. Produces a one-cycle advance pulse
// once every (div+1) selected ticks while enabled.
// Assumes ticks are single-cycle enables in the system clock domain.
module cmp_timer_prescale
    import cmp_timer_pkg::*;
#(
    parameter int unsigned PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             phase_clr,
    input  logic             enable,
    input  logic [2:0]       src_sel,
    input  logic [PRE_W-1:0] div_val,
    input  logic             tick_per,
    input  logic             tick_slow,
    output logic             adv
);
    logic             src_tick;
    logic [PRE_W-1:0] phase_q;

    // Decode the source code into a tick.
    always_comb begin
        case (src_code_e'(src_sel))
            SRC_PER_A, SRC_PER_B: src_tick = tick_per;
            SRC_SLOW:             src_tick = tick_slow;
            default:              src_tick = 1'b0;
        endcase
        adv = enable && src_tick && (phase_q >= div_val);
    end

    // Divider phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || phase_clr)
            phase_q <= '0;
        else if (enable && src_tick)
            phase_q <= adv ? '0 : phase_q + 1'b1;
    end
endmodule

// File: rtl/cmp_timer_counter.sv
`timescale 1ns/1ps
// Main counter, per-channel compare, and status flags. Flags set on an
// advance step; a bus write-one clear loses to a simultaneous set.
module cmp_timer_counter
    import cmp_timer_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned NUM_CMP = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          soft_rst,
    input  logic                          cnt_clr,
    input  logic                          adv,
    input  logic                          free_run,
    input  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q,
    input  logic [ST_W-1:0]               sts_clr,
    output logic [CNT_W-1:0]              cnt_q,
    output logic [ST_W-1:0]               sts_q
);
    logic [NUM_CMP-1:0] hit;
    logic [ST_W-1:0]    sts_set;
    logic               at_max;

    // Equality comparators, one per channel.
    for (genvar c = 0; c < NUM_CMP; c++) begin : g_hit
        assign hit[c] = (cnt_q == cmp_q[c]);
    end

    // Flags raised by this step.
    always_comb begin
        at_max  = &cnt_q;
        sts_set = '0;
        for (int k = 0; k < NUM_CMP; k++)
            sts_set[k] = adv && hit[k];
        sts_set[ST_ROLL] = adv && at_max;
    end

    // Counter: clear, restart on compare 1, or increment with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || cnt_clr)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= (!free_run && hit[0]) ? '0 : cnt_q + 1'b1;
    end

    // Status flags: set wins over write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            sts_q <= '0;
        else
            sts_q <= (sts_q & ~sts_clr) | sts_set;
    end
endmodule

// File: rtl/cmp_timer_top.sv
`timescale 1ns/1ps
// Compare timer top: ties registers, divider and counter together, provides
// the combinational read mux and the level interrupt.
// Assumes CNT_W <= DATA_W and NUM_CMP <= 3.
module cmp_timer_top
    import cmp_timer_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned PRE_W   = 12,
    parameter int unsigned NUM_CMP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_per,
    input  logic              tick_slow,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0]             ctrl_q;
    logic [PRE_W-1:0]              div_q;
    logic [ST_W-1:0]               ien_q;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
    logic                          soft_rst, en_start, cmp1_clr, adv;
    logic [ST_W-1:0]               sts_clr, sts_q;
    logic [CNT_W-1:0]              cnt_q;

    cmp_timer_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W), .NUM_CMP(NUM_CMP)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .div_q(div_q), .ien_q(ien_q),
        .cmp_q(cmp_q), .soft_rst(soft_rst), .en_start(en_start),
        .cmp1_clr(cmp1_clr), .sts_clr(sts_clr)
    );

    cmp_timer_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .phase_clr(en_start),
        .enable(ctrl_q[CB_EN]), .src_sel(ctrl_q[CB_SRC_LO +: 3]),
        .div_val(div_q), .tick_per(tick_per), .tick_slow(tick_slow), .adv(adv)
    );

    cmp_timer_counter #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_cnt (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cnt_clr(en_start || cmp1_clr), .adv(adv),
        .free_run(ctrl_q[CB_FREE]), .cmp_q(cmp_q), .sts_clr(sts_clr),
        .cnt_q(cnt_q), .sts_q(sts_q)
    );

    // Read mux by word index; unmapped and capture indices read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == IDX_CTRL)        bus_rdata = ctrl_q;
        else if (bus_addr == IDX_DIV)    bus_rdata = DATA_W'(div_q);
        else if (bus_addr == IDX_STATUS) bus_rdata = DATA_W'(sts_q);
        else if (bus_addr == IDX_IEN)    bus_rdata = DATA_W'(ien_q);
        else if (bus_addr == IDX_COUNT)  bus_rdata = DATA_W'(cnt_q);
        else begin
            for (int c = 0; c < NUM_CMP; c++)
                if (bus_addr == IDX_CMP0 + 4'(c))
                    bus_rdata = DATA_W'(cmp_q[c]);
        end
    end

    // Level interrupt from masked flags while enabled.
    assign irq = ctrl_q[CB_EN] && |(sts_q & ien_q);
endmodule

// File: rtl/cmp_timer_checker.sv
`timescale 1ns/1ps
// Property checker for the compare timer, bound into the top module.
module cmp_timer_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [3:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             irq,
    input logic [31:0]      ctrl,
    input logic [5:0]       ie,
    input logic [5:0]       sts,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp1
);
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |-> !irq);
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & ie) == 6'd0) |-> !irq);
    a_r11_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[0] && !bus_we) |=> $stable(cnt));
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == '0));
    a_r5_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && ctrl[9] && !bus_we && (&cnt)) |=> ((&cnt) || (cnt == '0 && sts[5])));
    a_r6_restart_match: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && !ctrl[9] && !bus_we && cnt == cmp1)
        |=> (cnt == $past(cnt) || (cnt == '0 && sts[0])));
    a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 4'd0 && bus_wdata[15])
        |=> (ctrl[5:0] == 6'd0 && !ctrl[15] && ctrl[9] == $past(bus_wdata[9])
             && cnt == '0 && sts == 6'd0));
    a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 4'd2 && !ctrl[0]) |=> ((sts & $past(bus_wdata[5:0])) == 6'd0));
endmodule

bind cmp_timer_top cmp_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq(irq), .ctrl(ctrl_q), .ie(ien_q),
    .sts(sts_q), .cnt(cnt_q), .cmp1(cmp_q[0])
);

// File: tb/cmp_timer_top_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, checked against a
// requirement-level model kept in bench variables.
module cmp_timer_top_test;
    localparam int unsigned CW = 10;
    localparam logic [31:0] CMAX = (32'd1 << CW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick_per = 0, tick_slow = 0, bus_we = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cmp_timer_top #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .tick_per(tick_per), .tick_slow(tick_slow),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // Requirement-level model state.
    logic [31:0] m_ctrl, m_cnt, m_pc, m_pre;
    logic [5:0]  m_ie, m_sts;
    logic [31:0] m_cmp [3];

    function automatic logic [31:0] mread(input logic [3:0] i);
        case (i)
            4'd0: return m_ctrl;
            4'd1: return m_pre;
            4'd2: return {26'd0, m_sts};
            4'd3: return {26'd0, m_ie};
            4'd4: return m_cmp[0];
            4'd5: return m_cmp[1];
            4'd6: return m_cmp[2];
            4'd9: return m_cnt;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic m_irq();
        return m_ctrl[0] && (|(m_sts & m_ie));
    endfunction

    // Model update at each edge from the same inputs the design sees.
    always @(posedge clk) begin
        logic tk, adv, st, crst;
        logic [5:0] set, clr;
        logic [31:0] ncnt, npc;
        if (!rst_n) begin
            m_ctrl = 0; m_pre = 0; m_ie = 0; m_sts = 0; m_cnt = 0; m_pc = 0;
            for (int k = 0; k < 3; k++) m_cmp[k] = CMAX;
        end else if (bus_we && bus_addr == 4'd0 && bus_wdata[15]) begin
            m_ctrl = bus_wdata & 32'hFFFF_03C0;
            m_pre = 0; m_ie = 0; m_sts = 0; m_cnt = 0; m_pc = 0;
            for (int k = 0; k < 3; k++) m_cmp[k] = CMAX;
        end else begin
            case (m_ctrl[8:6])
                3'd1, 3'd2: tk = tick_per;
                3'd4:       tk = tick_slow;
                default:    tk = 1'b0;
            endcase
            adv = m_ctrl[0] && tk && (m_pc >= m_pre);
            set = 0;
            for (int k = 0; k < 3; k++) if (adv && m_cnt == m_cmp[k]) set[k] = 1'b1;
            if (adv && m_cnt == CMAX) set[5] = 1'b1;
            st   = bus_we && bus_addr == 4'd0 && !m_ctrl[0] && bus_wdata[0] && bus_wdata[1];
            crst = bus_we && bus_addr == 4'd4 && !m_ctrl[9];
            ncnt = m_cnt;
            if (st || crst) ncnt = 0;
            else if (adv) ncnt = (!m_ctrl[9] && m_cnt == m_cmp[0]) ? 0 : ((m_cnt + 1) & CMAX);
            npc = m_pc;
            if (st) npc = 0;
            else if (m_ctrl[0] && tk) npc = adv ? 0 : m_pc + 1;
            clr = (bus_we && bus_addr == 4'd2) ? bus_wdata[5:0] : 6'd0;
            m_sts = (m_sts & ~clr) | set;
            m_cnt = ncnt; m_pc = npc;
            if (bus_we) begin
                case (bus_addr)
                    4'd0: m_ctrl = bus_wdata & 32'hFFFF_03EB;
                    4'd1: m_pre = bus_wdata & 32'hFFF;
                    4'd3: m_ie = bus_wdata[5:0];
                    4'd4: m_cmp[0] = bus_wdata & CMAX;
                    4'd5: m_cmp[1] = bus_wdata & CMAX;
                    4'd6: m_cmp[2] = bus_wdata & CMAX;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input logic [3:0] idx, input logic [31:0] exp, input string tag);
        bus_addr = idx; #0.2;
        total++;
        if (bus_rdata !== exp) begin
            bad++;
            $display("FAIL %s idx=%0d actual=%h expected=%h", tag, idx, bus_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        total++;
        if (irq !== exp) begin
            bad++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    task automatic chk_m(input logic [3:0] idx, input string tag);
        chk(idx, mread(idx), tag);
    endtask

    task automatic sync_chk(input string tag);
        chk_m(4'd9, tag); chk_m(4'd2, tag); chk_irq(m_irq(), tag);
    endtask

    task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d,
                        input logic tp, input logic ts);
        bus_we = we; bus_addr = a; bus_wdata = d; tick_per = tp; tick_slow = ts;
        @(negedge clk);
        bus_we = 0; tick_per = 0; tick_slow = 0;
        #0.1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic ticks(input int n, input logic tp, input logic ts);
        for (int k = 0; k < n; k++) step(1'b0, 4'd0, 32'd0, tp, ts);
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #0.1;

        // R1 reset values
        chk(4'd0, 0, "R1 ctrl"); chk(4'd1, 0, "R1 div"); chk(4'd2, 0, "R1 status");
        chk(4'd3, 0, "R1 ien"); chk(4'd4, CMAX, "R1 cmp1"); chk(4'd5, CMAX, "R1 cmp2");
        chk(4'd6, CMAX, "R1 cmp3"); chk(4'd9, 0, "R1 count"); chk_irq(1'b0, "R1 irq");

        // R2 masks and ignored indices
        wr(4'd0, 32'hFFFF_7FFC); chk(4'd0, 32'hFFFF_03E8, "R2 ctrl mask");
        wr(4'd1, 32'hFFFF_FFFF); chk(4'd1, 32'h0000_0FFF, "R2 div mask");
        wr(4'd3, 32'hFFFF_FFFF); chk(4'd3, 32'h0000_003F, "R2 ien mask");
        wr(4'd9, 32'h0000_0123); chk(4'd9, 0, "R2 count write ignored");
        wr(4'd7, 32'h0000_0055); chk(4'd7, 0, "R2 capture reads zero");
        chk(4'd8, 0, "R2 capture2"); chk(4'd12, 0, "R2 unmapped");
        wr(4'd0, 0); wr(4'd3, 0); wr(4'd1, 2);

        // R3 / R4: source 1, divider 2 -> 3 advances in 9 ticks
        wr(4'd0, 32'h241);
        ticks(9, 1'b1, 1'b0); chk(4'd9, 3, "R4 divide by 3");
        ticks(5, 1'b0, 1'b1); chk(4'd9, 3, "R3 slow tick ignored on code 1");
        wr(4'd0, 32'h301);
        ticks(3, 1'b0, 1'b1); chk(4'd9, 4, "R3 slow tick on code 4");
        wr(4'd0, 32'h2C1);
        ticks(6, 1'b1, 1'b1); chk(4'd9, 4, "R3 code 3 no clock");

        // R11 freeze, resume, restart
        wr(4'd0, 32'h240);
        ticks(6, 1'b1, 1'b0); chk(4'd9, 4, "R11 frozen");
        wr(4'd0, 32'h241);
        ticks(3, 1'b1, 1'b0); chk(4'd9, 5, "R11 resume");
        wr(4'd0, 32'h240); wr(4'd0, 32'h243); chk(4'd9, 0, "R11 restart on enable");

        // R5 wrap with rollover; R7 all compares at max; R9 irq; R8 clear
        wr(4'd1, 0); wr(4'd3, 32'h20);
        ticks(int'(CMAX), 1'b1, 1'b0); chk(4'd9, CMAX, "R5 at max");
        chk(4'd2, 0, "R5 no flag before wrap");
        ticks(1, 1'b1, 1'b0); chk(4'd9, 0, "R5 wrap to zero");
        chk(4'd2, 32'h27, "R7 multi match + R5 rollover"); chk_irq(1'b1, "R9 irq raised");
        wr(4'd2, 32'h20); chk(4'd2, 32'h07, "R8 clear rollover"); chk_irq(1'b0, "R9 irq masked");
        wr(4'd3, 32'h01); chk_irq(1'b1, "R9 irq on ch1");
        wr(4'd0, 32'h240); chk_irq(1'b0, "R9 irq needs enable");

        // R10 soft reset
        wr(4'd0, 32'h8241);
        chk(4'd0, 32'h240, "R10 ctrl kept"); chk(4'd2, 0, "R10 status");
        chk(4'd3, 0, "R10 ien"); chk(4'd4, CMAX, "R10 cmp1"); chk(4'd9, 0, "R10 count");
        chk(4'd1, 0, "R10 div");

        // R6 restart mode, R7 two channels at once
        wr(4'd4, 5); wr(4'd5, 5); wr(4'd6, 9);
        wr(4'd0, 32'h043);
        ticks(5, 1'b1, 1'b0); chk(4'd9, 5, "R6 at compare");
        ticks(1, 1'b1, 1'b0); chk(4'd9, 0, "R6 restart after match");
        chk(4'd2, 32'h03, "R7 two flags together");
        ticks(3, 1'b1, 1'b0); chk(4'd9, 3, "R6 counting");
        wr(4'd4, 7); chk(4'd9, 0, "R6 compare write clears count");

        // Random traffic against the model (R3 R4 R5 R6 R7 R8 R9 R10 R11)
        for (int n = 0; n < 3000; n++) begin
            logic [3:0]  a;
            logic [31:0] d;
            logic        we;
            we = ($urandom % 100) < 30;
            a = 4'($urandom % 16);
            d = $urandom;
            case (a)
                4'd0: begin
                    logic [2:0] codes [5] = '{3'd1, 3'd2, 3'd4, 3'd0, 3'd3};
                    d = d & 32'h0000_02FF;
                    d[8:6] = codes[$urandom % 5];
                    d[0] = ($urandom % 5) != 0;
                    d[15] = ($urandom % 25) == 0;
                end
                4'd1: d = $urandom % 4;
                4'd4, 4'd5, 4'd6: d = $urandom % 48;
                default: ;
            endcase
            step(we, a, d, ($urandom % 4) != 0, ($urandom % 3) == 0);
            sync_chk("R7 R8 R9 random");
            if (n % 64 == 0)
                for (int i = 0; i < 10; i++) chk_m(4'(i), "R2 R10 R11 random readback");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule